// File: doc/BRIEF.md
# Boot Sector Protection and Erase Region Decoder

This block sits beside the command engine of a word-addressed flash memory controller. For each requested operation it decides which storage regions may be changed. The array holds 512K words of 16 bits. It is split into an 8K-word boot block, two 8K-word parameter blocks and a 488K-word main array. Erase works on three sectors: each parameter block on its own, and a combined sector made of the boot block and the main array. A build parameter selects the layout. In the top layout the boot block holds the highest addresses. In the bottom layout the order is mirrored from address zero.

A single flag records whether boot lockout has been turned on. It models a non-volatile bit. Only a lock request sets it, and a reset never clears it. Its power-up value comes from a parameter. While the flag is set, the boot block is left out of programs and erases, unless the high-voltage override input is high in that cycle. The permit mask is combinational, so the engine samples it in the same cycle it presents the request. An identification read of word address 00002h returns the flag on data bit 0.

Top module: `flash_prot_top`

## Requirements
- R1: The permit mask uses bit 0 for boot, bit 1 for parameter 1, bit 2 for parameter 2 and bit 3 for main. With the top layout (TOP_BOOT=1), a program (op code 1) sets only the bit of the region that holds the address: boot 7E000h-7FFFFh, parameter 1 7C000h-7DFFFh, parameter 2 7A000h-7BFFFh, main 00000h-79FFFh.
- R2: With the bottom layout (TOP_BOOT=0) the regions are boot 00000h-01FFFh, parameter 1 02000h-03FFFh, parameter 2 04000h-05FFFh and main 06000h-7FFFFh.
- R3: A sector erase (op code 2) at an address in a parameter block permits that parameter block and nothing else.
- R4: While unlocked, a sector erase at a boot or main address permits both boot and main (mask 1001b). A chip erase (op code 3) permits all four regions.
- R5: While locked and without override, a sector erase at a boot or main address permits main only (1000b). A chip erase permits 1110b.
- R6: While locked and without override, a program to a boot address gives mask 0000b. Programs to other regions are unaffected.
- R7: With hv_override high, a locked block behaves as unlocked in that cycle. The lockout applies again in the first cycle the override is low.
- R8: A lock request (op code 4 with req_valid, outside reset) sets lock_status from the next clock edge on. The flag is sticky across later requests and resets, and starts at LOCK_INIT.
- R9: While rst_n is low the permit mask is zero and lock requests are ignored.
- R10: With id_mode high and address 00002h, id_data bit 0 equals the lock flag and all other bits are 0. For any other address, or with id_mode low, id_data is zero.
- R11: With req_valid low, or with op code 0 or 4, the permit mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; halts permits, keeps the lock flag |
| addr | input | 19 | Word address of the request |
| op | input | 3 | 0 none, 1 program, 2 sector erase, 3 chip erase, 4 lock enable |
| req_valid | input | 1 | Request present this cycle |
| hv_override | input | 1 | High-voltage lockout override |
| id_mode | input | 1 | Identification read mode |
| permit | output | 4 | Per-region permit mask (boot, param1, param2, main) |
| lock_status | output | 1 | Boot lockout flag |
| id_data | output | 16 | Identification read word |

## Verification
The only internal state is the lock flag. A wrong flag shows at once through lock_status and the identification word. It also shows in the next erase aimed at the combined sector, where bit 0 of the mask is then wrong. A flag that sets late, or one that a reset clears, is caught in the first cycle after the lock request or after the reset pulse. The bench also models the address decode independently, once for each layout, so a wrong decode shows in the same cycle as the request.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
    localparam int NUM_REGIONS = 4;
    localparam int RG_BOOT  = 0;
    localparam int RG_PAR1  = 1;
    localparam int RG_PAR2  = 2;
    localparam int RG_MAIN  = 3;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROG       = 3'd1,
        OP_SECT_ERASE = 3'd2,
        OP_CHIP_ERASE = 3'd3,
        OP_LOCK       = 3'd4
    } flash_op_e;

    typedef struct packed {
        logic locked;
    } prot_state_t;
endpackage

// File: rtl/flash_region_dec.sv
module flash_region_dec
    import flash_prot_pkg::*;
#(
    parameter int TAG_W    = 6,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [TAG_W-1:0]       blk_tag,
    output logic [NUM_REGIONS-1:0] region
);
    logic [TAG_W-1:0] rank;

    generate
        if (TOP_BOOT) begin : g_top
            assign rank = ~blk_tag;
        end else begin : g_bottom
            assign rank = blk_tag;
        end
    endgenerate

    always_comb begin
        region = '0;
        if (rank == TAG_W'(0))      region[RG_BOOT] = 1'b1;
        else if (rank == TAG_W'(1)) region[RG_PAR1] = 1'b1;
        else if (rank == TAG_W'(2)) region[RG_PAR2] = 1'b1;
        else                        region[RG_MAIN] = 1'b1;
    end
endmodule

// File: rtl/flash_permit_calc.sv
module flash_permit_calc
    import flash_prot_pkg::*;
(
    input  logic [NUM_REGIONS-1:0] region,
    input  flash_op_e              op,
    input  logic                   req_valid,
    input  logic                   active,
    input  logic                   locked,
    input  logic                   override,
    output logic [NUM_REGIONS-1:0] mask
);
    logic boot_open;
    assign boot_open = !locked || override;

    always_comb begin
        mask = '0;
        if (active && req_valid) begin
            case (op)
                OP_PROG: begin
                    mask = region;
                    if (region[RG_BOOT] && !boot_open) mask = '0;
                end
                OP_SECT_ERASE: begin
                    if (region[RG_PAR1] || region[RG_PAR2]) begin
                        mask = region;
                    end else begin
                        mask[RG_MAIN] = 1'b1;
                        mask[RG_BOOT] = boot_open;
                    end
                end
                OP_CHIP_ERASE: begin
                    mask[RG_MAIN] = 1'b1;
                    mask[RG_PAR1] = 1'b1;
                    mask[RG_PAR2] = 1'b1;
                    mask[RG_BOOT] = boot_open;
                end
                default: mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_prot_top.sv
module flash_prot_top
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int BLK_W        = 13,
    parameter int DATA_W       = 16,
    parameter int ID_LOCK_ADDR = 2,
    parameter bit TOP_BOOT     = 1'b1,
    parameter bit LOCK_INIT    = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [2:0]             op,
    input  logic                   req_valid,
    input  logic                   hv_override,
    input  logic                   id_mode,
    output logic [NUM_REGIONS-1:0] permit,
    output logic                   lock_status,
    output logic [DATA_W-1:0]      id_data
);
    localparam int TAG_W = ADDR_W - BLK_W;

    flash_op_e                op_e;
    logic [NUM_REGIONS-1:0]   region;
    prot_state_t              st_d;
    prot_state_t              st_q = '{locked: LOCK_INIT};

    assign op_e = flash_op_e'(op);

    flash_region_dec #(
        .TAG_W   (TAG_W),
        .TOP_BOOT(TOP_BOOT)
    ) region_dec_i (
        .blk_tag(addr[ADDR_W-1:BLK_W]),
        .region (region)
    );

    flash_permit_calc permit_calc_i (
        .region   (region),
        .op       (op_e),
        .req_valid(req_valid),
        .active   (rst_n),
        .locked   (st_q.locked),
        .override (hv_override),
        .mask     (permit)
    );

    always_comb begin
        st_d = st_q;
        if (rst_n && req_valid && op_e == OP_LOCK) st_d.locked = 1'b1;
    end

    // Non-volatile flag: reset deliberately leaves it alone.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lock_status = st_q.locked;

    always_comb begin
        id_data = '0;
        if (id_mode && addr == ADDR_W'(ID_LOCK_ADDR)) id_data[0] = st_q.locked;
    end
endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        op,
    input logic              req_valid,
    input logic              hv_override,
    input logic              id_mode,
    input logic [3:0]        permit,
    input logic              lock_status,
    input logic [DATA_W-1:0] id_data
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_status |=> lock_status); // R8
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == 3'd4) |=> lock_status); // R8
    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_status && !hv_override) |-> !permit[0]); // R6
    AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |-> $onehot0(permit)); // R1
    AST_SECT_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 && (permit[1] || permit[2])) |-> $countones(permit) == 1); // R3
    AST_SECT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 && !lock_status && permit[3]) |-> permit[0]); // R4
    AST_CHIP_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && req_valid) |-> permit[3:1] == 3'b111); // R5
    AST_OVR_LIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && req_valid && hv_override) |-> permit[0]); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> permit == 4'b0000); // R11
    AST_ID_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr == ADDR_W'(2)) |-> id_data[DATA_W-1:1] == '0); // R10

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (permit == 4'b0000); // R9
        end
    end
endmodule

bind flash_prot_top flash_prot_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .op         (op),
    .req_valid  (req_valid),
    .hv_override(hv_override),
    .id_mode    (id_mode),
    .permit     (permit),
    .lock_status(lock_status),
    .id_data    (id_data)
);

// File: tb/flash_prot_top_tb_top.sv
`timescale 1ns/1ps
module flash_prot_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic [2:0]  op = '0;
    logic        req_valid = 1'b0;
    logic        hv_override = 1'b0;
    logic        id_mode = 1'b0;
    logic [3:0]  permit_t, permit_b;
    logic        lock_t_o, lock_b_o;
    logic [15:0] id_t, id_b;

    bit lock_t = 1'b0;
    bit lock_b = 1'b1;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    flash_prot_top #(.TOP_BOOT(1'b1), .LOCK_INIT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .op(op), .req_valid(req_valid),
        .hv_override(hv_override), .id_mode(id_mode),
        .permit(permit_t), .lock_status(lock_t_o), .id_data(id_t));

    flash_prot_top #(.TOP_BOOT(1'b0), .LOCK_INIT(1'b1)) dut_bot_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .op(op), .req_valid(req_valid),
        .hv_override(hv_override), .id_mode(id_mode),
        .permit(permit_b), .lock_status(lock_b_o), .id_data(id_b));

    always @(posedge clk) begin
        if (rst_n && req_valid && op == 3'd4) begin
            lock_t <= 1'b1;
            lock_b <= 1'b1;
        end
    end

    function automatic logic [3:0] region_of(logic [18:0] a, bit top);
        if (top) begin
            if (a >= 19'h7E000) return 4'b0001;
            if (a >= 19'h7C000) return 4'b0010;
            if (a >= 19'h7A000) return 4'b0100;
            return 4'b1000;
        end
        if (a < 19'h02000) return 4'b0001;
        if (a < 19'h04000) return 4'b0010;
        if (a < 19'h06000) return 4'b0100;
        return 4'b1000;
    endfunction

    function automatic logic [3:0] exp_mask(logic [18:0] a, logic [2:0] o, bit v,
                                            bit rn, bit lk, bit ov, bit top);
        logic [3:0] r = region_of(a, top);
        bit open = !lk || ov;
        if (!rn || !v) return 4'b0000;
        case (o)
            3'd1: return (r == 4'b0001 && !open) ? 4'b0000 : r;
            3'd2: return (r[1] || r[2]) ? r : {3'b100, open};
            3'd3: return {3'b111, open};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_id(logic [18:0] a, bit idm, bit lk);
        return (idm && a == 19'd2) ? {15'd0, lk} : 16'd0;
    endfunction

    task automatic checkv(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [18:0] a, logic [2:0] o, bit v, bit ov, bit idm);
        @(negedge clk);
        addr = a; op = o; req_valid = v; hv_override = ov; id_mode = idm;
        #2;
    endtask

    task automatic dir_t(string tag, logic [18:0] a, logic [2:0] o, bit ov, logic [3:0] exp);
        drive(a, o, 1'b1, ov, 1'b0);
        checkv(tag, {12'd0, permit_t}, {12'd0, exp});
    endtask

    task automatic dir_b(string tag, logic [18:0] a, logic [2:0] o, bit ov, logic [3:0] exp);
        drive(a, o, 1'b1, ov, 1'b0);
        checkv(tag, {12'd0, permit_b}, {12'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset state and lock request during reset (R9, R8)
        drive(19'h00000, 3'd3, 1'b1, 1'b0, 1'b0);
        checkv("R9 permit in reset", {12'd0, permit_t}, 16'd0);
        checkv("R8 init top", {15'd0, lock_t_o}, 16'd0);
        checkv("R8 init bottom", {15'd0, lock_b_o}, 16'd1);
        drive(19'h00000, 3'd4, 1'b1, 1'b0, 1'b0);
        drive(19'h00000, 3'd0, 1'b0, 1'b0, 1'b0);
        checkv("R9 lock ignored in reset", {15'd0, lock_t_o}, 16'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 top decode edges
        dir_t("R1", 19'h7FFFF, 3'd1, 0, 4'b0001);
        dir_t("R1", 19'h7E000, 3'd1, 0, 4'b0001);
        dir_t("R1", 19'h7DFFF, 3'd1, 0, 4'b0010);
        dir_t("R1", 19'h7C000, 3'd1, 0, 4'b0010);
        dir_t("R1", 19'h7BFFF, 3'd1, 0, 4'b0100);
        dir_t("R1", 19'h7A000, 3'd1, 0, 4'b0100);
        dir_t("R1", 19'h79FFF, 3'd1, 0, 4'b1000);
        dir_t("R1", 19'h00000, 3'd1, 0, 4'b1000);
        // R2 bottom decode (bottom instance starts locked)
        dir_b("R2", 19'h02000, 3'd1, 0, 4'b0010);
        dir_b("R2", 19'h05FFF, 3'd1, 0, 4'b0100);
        dir_b("R2", 19'h06000, 3'd1, 0, 4'b1000);
        dir_b("R6 bottom boot locked", 19'h01FFF, 3'd1, 0, 4'b0000);
        dir_b("R7 bottom boot override", 19'h00000, 3'd1, 1, 4'b0001);
        dir_b("R7 override removed", 19'h00000, 3'd1, 0, 4'b0000);
        // R3, R4 top unlocked
        dir_t("R3", 19'h7C100, 3'd2, 0, 4'b0010);
        dir_t("R3", 19'h7A000, 3'd2, 0, 4'b0100);
        dir_t("R4 sect main", 19'h01000, 3'd2, 0, 4'b1001);
        dir_t("R4 sect boot", 19'h7E000, 3'd2, 0, 4'b1001);
        dir_t("R4 chip", 19'h12345, 3'd3, 0, 4'b1111);
        // R11
        drive(19'h01000, 3'd2, 1'b0, 1'b0, 1'b0);
        checkv("R11 no valid", {12'd0, permit_t}, 16'd0);
        dir_t("R11 lock op", 19'h01000, 3'd4, 0, 4'b0000);
        drive(19'h00002, 3'd0, 1'b1, 1'b0, 1'b1);
        checkv("R11 none op", {12'd0, permit_t}, 16'd0);
        // lock was requested by R11 lock op above
        checkv("R8 set next cycle", {15'd0, lock_t_o}, 16'd1);
        checkv("R10 id locked", id_t, 16'h0001);
        drive(19'h00003, 3'd0, 1'b0, 1'b0, 1'b1);
        checkv("R10 other addr", id_t, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(19'h00002, 3'd0, 1'b0, 1'b0, 1'b0);
        checkv("R8 survives reset", {15'd0, lock_t_o}, 16'd1);
        checkv("R10 id_mode low", id_t, 16'h0000);
        // R5, R6, R7 top locked
        dir_t("R5 sect", 19'h01000, 3'd2, 0, 4'b1000);
        dir_t("R5 chip", 19'h01000, 3'd3, 0, 4'b1110);
        dir_t("R6 boot prog", 19'h7E005, 3'd1, 0, 4'b0000);
        dir_t("R6 par prog", 19'h7C005, 3'd1, 0, 4'b0010);
        dir_t("R7 sect", 19'h7F000, 3'd2, 1, 4'b1001);
        dir_t("R7 chip", 19'h7F000, 3'd3, 1, 4'b1111);
        dir_t("R7 prog", 19'h7F000, 3'd1, 1, 4'b0001);
        dir_t("R7 reapplied", 19'h7F000, 3'd1, 0, 4'b0000);

        // Random phase: both instances against the bench model
        for (int i = 0; i < 3000; i++) begin
            logic [18:0] a;
            logic [2:0]  o;
            case ($urandom % 4)
                0: a = 19'h7A000 + 19'($urandom % 24576);
                1: a = 19'($urandom % 24576);
                2: a = 19'd2;
                default: a = 19'($urandom);
            endcase
            o = 3'($urandom % 4);
            if ($urandom % 100 == 0) o = 3'd4;
            rst_n = ($urandom % 40 != 0);
            drive(a, o, ($urandom % 8 != 0), ($urandom % 4 == 0), ($urandom % 2 == 0));
            checkv("RND top mask", {12'd0, permit_t},
                   {12'd0, exp_mask(addr, op, req_valid, rst_n, lock_t, hv_override, 1'b1)});
            checkv("RND bottom mask", {12'd0, permit_b},
                   {12'd0, exp_mask(addr, op, req_valid, rst_n, lock_b, hv_override, 1'b0)});
            checkv("RND lock", {15'd0, lock_t_o}, {15'd0, lock_t});
            checkv("RND id", id_b, exp_id(addr, id_mode, lock_b));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule